// File: doc/BRIEF.md
# Scan Readout Stage with Backlog Counter

This block sits between a word-wide sample FIFO and a host reader. It takes one scan's worth of words out of the FIFO, one word per cycle, in a single contiguous burst, and assembles them into one wide scan record. The record waits in a holding register that the host reads through a valid/acknowledge handshake. The holding register is blocking: no burst begins while it holds a record that the host has not acknowledged, so a record is never overwritten.

Alongside the datapath the block keeps two wrapping counters. One counts scans that the producer reports as written, and the other counts scans that the host has acknowledged. Their modular difference is presented as the backlog. The backlog tells the host how many scans it may read without reading any scan twice. The subtraction is unsigned and modular, so the value stays correct after either counter wraps.

Top module: `scan_readout`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `scan_valid` is 0, `backlog` is 0 and `fifo_pop` is 0.
- R2: A pop burst starts only in a cycle where `fifo_level` is at least CHANS and the holding register is either empty or being acknowledged in that same cycle. Once started, the burst pops on CHANS consecutive cycles.
- R3: The k-th word popped in a burst (k counted from 0) lands in `scan_data[k*WORD_W +: WORD_W]`. `scan_valid` rises on the cycle after the last pop of the burst.
- R4: While `scan_valid` is 1 and `host_ack` is 0, `scan_valid` and `scan_data` keep their values and no new burst starts.
- R5: When `host_ack` is 1 while `scan_valid` is 1, the record is consumed and `scan_valid` falls on the next cycle. When `host_ack` is 1 while `scan_valid` is 0, it has no effect on `backlog` or on `scan_valid`.
- R6: Each cycle with `scan_written` high adds one to the written count. Each consumed record adds one to the delivered count. `backlog` equals written minus delivered, modulo 2^CNT_W, and is updated one cycle after the event.
- R7: `backlog` stays correct after either counter wraps past 2^CNT_W-1.
- R8: This requirement assumes the producer pulses `scan_written` no later than the cycle in which the scan's last word enters the FIFO. Under that condition, `backlog` is nonzero whenever `scan_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_level | input | LVL_W | Number of words currently held in the FIFO |
| fifo_word | input | WORD_W | Word at the FIFO head (show-ahead) |
| fifo_pop | output | 1 | Removes the head word at the clock edge |
| scan_written | input | 1 | One-cycle pulse for each scan written by the producer |
| scan_valid | output | 1 | Holding register contains an unread record |
| scan_data | output | WORD_W*CHANS | Assembled scan record, channel 0 in the low bits |
| host_ack | input | 1 | Host has read the record |
| backlog | output | CNT_W | Scans written minus scans delivered, modular |

## Verification
The bench runs the readout against its own queue-based FIFO. It covers the following cases:
- A single scan that the host leaves unread for several cycles, which separates a blocking holding register from one that refills.
- A scan that arrives in two halves, which shows whether the burst waits for a full scan or starts on a partial one.
- Acknowledges driven while nothing is valid, which would expose an ack that is not gated by the valid flag.
- Back-to-back scans with the acknowledge held high, which exercise the refill in the same cycle as the handover.

A long randomized run with a narrow counter width makes both counters wrap many times. In that run, a plain (non-modular) difference or a delivered count taken at pop time would disagree with the model.

// File: rtl/scan_readout_pkg.sv
package scan_readout_pkg;

   // Index width that stays legal for a single-entry structure.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/scan_gather.sv
module scan_gather
   import scan_readout_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CHANS  = 4,
   parameter int unsigned LVL_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LVL_W-1:0]        fifo_level,
   input  logic [WORD_W-1:0]       fifo_word,
   input  logic                    hold_free,
   output logic                    fifo_pop,
   output logic                    rec_load,
   output logic [WORD_W*CHANS-1:0] rec_data
);

   localparam int unsigned IDX_W = idx_width(CHANS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHANS - 1);

   logic             busy;
   logic [IDX_W-1:0] idx;
   logic             start;
   logic             last;

   assign start    = !busy && (fifo_level >= LVL_W'(CHANS)) && hold_free;
   assign fifo_pop = busy || start;
   assign last     = fifo_pop && (idx == LAST_IDX);
   assign rec_load = last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (fifo_pop) begin
         busy <= !last;
         idx  <= last ? '0 : idx + 1'b1;
      end
   end

   // Earlier lanes are registered; the final lane passes straight through
   // so the record is complete on the cycle of the last pop.
   for (genvar g = 0; g < CHANS; g++) begin : g_lane
      if (g == CHANS - 1) begin : g_direct
         assign rec_data[g*WORD_W +: WORD_W] = fifo_word;
      end else begin : g_reg
         logic [WORD_W-1:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lane_q <= '0;
            else if (fifo_pop && (idx == IDX_W'(g)))
               lane_q <= fifo_word;
         end
         assign rec_data[g*WORD_W +: WORD_W] = lane_q;
      end
   end

   assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (fifo_level != '0));

   assert_burst_contig_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && !rec_load) |=> fifo_pop);

endmodule

// File: rtl/scan_hold.sv
module scan_hold #(
   parameter int unsigned REC_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rec_load,
   input  logic [REC_W-1:0] rec_data,
   input  logic             host_ack,
   output logic             scan_valid,
   output logic [REC_W-1:0] scan_data,
   output logic             hold_free,
   output logic             take
);

   assign take      = scan_valid && host_ack;
   assign hold_free = !scan_valid || host_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_valid <= 1'b0;
         scan_data  <= '0;
      end else begin
         if (rec_load) begin
            scan_valid <= 1'b1;
            scan_data  <= rec_data;
         end else if (take) begin
            scan_valid <= 1'b0;
         end
      end
   end

   assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_valid && !host_ack) |=> (scan_valid && $stable(scan_data)));

   assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rec_load |-> (!scan_valid || host_ack));

   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_valid && host_ack && !rec_load) |=> !scan_valid);

endmodule

// File: rtl/scan_tally.sv
module scan_tally #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             written_inc,
   input  logic             deliver_inc,
   output logic [CNT_W-1:0] backlog
);

   logic [CNT_W-1:0] wr_cnt;
   logic [CNT_W-1:0] dl_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_cnt <= '0;
         dl_cnt <= '0;
      end else begin
         if (written_inc) wr_cnt <= wr_cnt + 1'b1;
         if (deliver_inc) dl_cnt <= dl_cnt + 1'b1;
      end
   end

   // Modular difference: correct through wrap of either counter.
   assign backlog = wr_cnt - dl_cnt;

   assert_backlog_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (backlog == $past(backlog) + CNT_W'($past(written_inc))
                                          - CNT_W'($past(deliver_inc))));

endmodule

// File: rtl/scan_readout.sv
module scan_readout #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned CHANS  = 4,
   parameter int unsigned LVL_W  = 8,
   parameter int unsigned CNT_W  = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LVL_W-1:0]        fifo_level,
   input  logic [WORD_W-1:0]       fifo_word,
   output logic                    fifo_pop,
   input  logic                    scan_written,
   output logic                    scan_valid,
   output logic [WORD_W*CHANS-1:0] scan_data,
   input  logic                    host_ack,
   output logic [CNT_W-1:0]        backlog
);

   localparam int unsigned REC_W = WORD_W * CHANS;

   initial begin
      assert (WORD_W >= 1) else $error("WORD_W must be at least 1");
      assert (CHANS >= 1) else $error("CHANS must be at least 1");
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
      assert (LVL_W <= 31 && CHANS < (1 << LVL_W))
         else $error("LVL_W too narrow to express CHANS");
   end

   logic             rec_load;
   logic [REC_W-1:0] rec_data;
   logic             hold_free;
   logic             take;

   scan_gather #(
      .WORD_W (WORD_W),
      .CHANS  (CHANS),
      .LVL_W  (LVL_W)
   ) u_gather (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_level (fifo_level),
      .fifo_word  (fifo_word),
      .hold_free  (hold_free),
      .fifo_pop   (fifo_pop),
      .rec_load   (rec_load),
      .rec_data   (rec_data)
   );

   scan_hold #(
      .REC_W (REC_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .rec_load   (rec_load),
      .rec_data   (rec_data),
      .host_ack   (host_ack),
      .scan_valid (scan_valid),
      .scan_data  (scan_data),
      .hold_free  (hold_free),
      .take       (take)
   );

   scan_tally #(
      .CNT_W (CNT_W)
   ) u_tally (
      .clk         (clk),
      .rst_n       (rst_n),
      .written_inc (scan_written),
      .deliver_inc (take),
      .backlog     (backlog)
   );

   assert_valid_backlog_R8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_valid |-> (backlog != '0));

endmodule

// File: tb/scan_readout_bench.sv
module scan_readout_bench;

   localparam int CLK_NS = 10;
   localparam int WORD_W = 16;
   localparam int CHANS  = 4;
   localparam int LVL_W  = 8;
   localparam int CNT_W  = 4;   // narrow so both counters wrap (R7)
   localparam int REC_W  = WORD_W * CHANS;
   localparam int unsigned MASK = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_NS/2) clk = ~clk;

   logic [LVL_W-1:0]  level_r = '0;
   logic [WORD_W-1:0] word_r  = '0;
   logic              ack_r   = 1'b0;
   logic              wr_r    = 1'b0;

   logic              fifo_pop;
   logic              scan_valid;
   logic [REC_W-1:0]  scan_data;
   logic [CNT_W-1:0]  backlog;

   scan_readout #(
      .WORD_W (WORD_W),
      .CHANS  (CHANS),
      .LVL_W  (LVL_W),
      .CNT_W  (CNT_W)
   ) u_scan_readout (
      .clk          (clk),
      .rst_n        (rst_n),
      .fifo_level   (level_r),
      .fifo_word    (word_r),
      .fifo_pop     (fifo_pop),
      .scan_written (wr_r),
      .scan_valid   (scan_valid),
      .scan_data    (scan_data),
      .host_ack     (ack_r),
      .backlog      (backlog)
   );

   // Reference model: a queue stands in for the FIFO
   logic [WORD_W-1:0] q[$];
   logic [WORD_W-1:0] pend[$];
   logic [WORD_W-1:0] m_cur[CHANS];
   int                m_got   = 0;
   bit                m_valid = 1'b0;
   logic [REC_W-1:0]  m_data  = '0;
   int unsigned       m_wr    = 0;
   int unsigned       m_dl    = 0;
   logic [WORD_W-1:0] seq     = 16'h1000;

   int n_chk = 0;
   int n_bad = 0;

   function automatic bit exp_pop();
      return (m_got != 0) || ((int'(level_r) >= CHANS) && (!m_valid || ack_r));
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit p;
         bit tk;
         p  = exp_pop();
         tk = m_valid && ack_r;
         if (tk) begin
            m_valid = 1'b0;
            m_dl++;
         end
         if (p) begin
            m_cur[m_got] = word_r;
            void'(q.pop_front());
            m_got++;
            if (m_got == CHANS) begin
               for (int k = 0; k < CHANS; k++) m_data[k*WORD_W +: WORD_W] = m_cur[k];
               m_valid = 1'b1;
               m_got   = 0;
            end
         end
         if (wr_r) m_wr++;
         while (pend.size() > 0) q.push_back(pend.pop_front());
      end
   end

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic compare();
      chk("R2 pop timing", 64'(fifo_pop), 64'(exp_pop()));
      chk("R3 R4 R5 valid", 64'(scan_valid), 64'(m_valid));
      if (m_valid) chk("R3 R4 record", 64'(scan_data), 64'(m_data));
      chk("R5 R6 R7 backlog", 64'(backlog), 64'((m_wr - m_dl) & MASK));
      if (scan_valid) chk("R8 backlog nonzero", 64'(backlog != '0), 64'd1);
   endtask

   task automatic tick(input bit ack, input int nwords, input bit wr);
      @(negedge clk);
      compare();
      ack_r = ack;
      wr_r  = wr;
      for (int i = 0; i < nwords; i++) begin
         pend.push_back(seq);
         seq = seq + 16'h0011;
      end
      level_r = LVL_W'(q.size());
      word_r  = (q.size() > 0) ? q[0] : '0;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R1 valid", 64'(scan_valid), 64'd0);
         chk("R1 backlog", 64'(backlog), 64'd0);
         chk("R1 pop", 64'(fifo_pop), 64'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after release", 64'(scan_valid), 64'd0);
      chk("R1 backlog after release", 64'(backlog), 64'd0);

      // R3 R4: single scan, host waits before reading
      tick(0, CHANS, 1);
      for (int i = 0; i < 10; i++) tick(0, 0, 0);
      tick(1, 0, 0);
      for (int i = 0; i < 3; i++) tick(0, 0, 0);

      // R2: half a scan must not start a burst
      tick(0, 2, 0);
      for (int i = 0; i < 5; i++) tick(0, 0, 0);
      tick(0, 2, 1);
      for (int i = 0; i < 7; i++) tick(0, 0, 0);
      tick(1, 0, 0);

      // R5: acknowledge with nothing valid
      for (int i = 0; i < 6; i++) tick(1, 0, 0);

      // R4 R5: three scans queued, acknowledge held high
      tick(0, CHANS, 1);
      tick(0, CHANS, 1);
      tick(0, CHANS, 1);
      for (int i = 0; i < 25; i++) tick(1, 0, 0);

      // R7: randomized traffic; counters wrap many times
      for (int i = 0; i < 3000; i++) begin
         bit ack;
         bit push;
         ack  = ($urandom_range(0, 2) != 0);
         push = (((m_wr - m_dl) & MASK) < 6) && ($urandom_range(0, 3) == 0);
         tick(ack, push ? CHANS : 0, push);
      end
      for (int i = 0; i < 60; i++) tick(1, 0, 0);
      tick(0, 0, 0);

      summary();
      $finish;
   end

endmodule